// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the running time base that a PWM output stage compares against. A prescaler built from two coded dividers derives a tick enable from the system clock. On each enabled tick a 16-bit counter moves according to the selected count mode: up, down, up then down, or frozen. The counter reports a one-cycle strobe when it sits at zero and another when it sits at the active period. A downstream action stage uses those strobes to set and clear its outputs.

Software programs the block through a single write port that selects either the control word or the period word. The period can be written straight into the active register, or written into a shadow copy that is moved into the active register at the next zero tick. This lets a new period start cleanly at a cycle boundary. A debug-halt input, combined with a run-control field, decides whether the counter stops on the next tick, stops once it has finished its current cycle at zero, or ignores the halt.

Top module: `pwm_timebase`

## Requirements
- R1: After a synchronous reset the counter reads 0, both strobes and the direction output are low, and the control word holds count mode 11 (frozen), shadow loading, divide by 1 and run control 00. The active and shadow periods are 0.
- R2: With wr_sel=0, wr_data[12:10] holds A and wr_data[9:7] holds B. The counter then advances once every 2^A * (B==0 ? 1 : 2*B) clocks, up to 1792.
- R3: Count mode wr_data[1:0]=00 counts up from 0 to the period P and then wraps to 0. prd_evt is high on the tick at P, and zero_evt is high on the tick at 0.
- R4: Count mode 01 counts down from P to 0 and reloads P after 0. dir_down is high in this mode.
- R5: Count mode 10 counts 0 up to P and back down to 0, repeating. dir_down is low while rising, including at P, and high while falling, including at 0.
- R6: Count mode 11 holds the counter at its current value and keeps both strobes low.
- R7: With load bit wr_data[3]=0 in the control word, a period write (wr_sel=1) goes to the shadow copy. It becomes active only on the zero tick that follows.
- R8: With load bit 1, a period write becomes active on the next clock. A counter at or above the new period wraps (up mode) on its next tick.
- R9: Run control wr_data[15:14]=00 with dbg_halt high holds the counter from the next tick with no strobes. Counting resumes once dbg_halt falls.
- R10: Run control 01 with dbg_halt high keeps counting until the counter reaches 0, then holds at 0 with no strobes.
- R11: Run control 10 or 11 counts normally whatever dbg_halt is.
- R12: Each strobe is one clock wide and occurs only on an enabled tick of a counting counter, once per counter cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 period word |
| wr_data | input | 16 | Write data |
| dbg_halt | input | 1 | Debug halt request, qualified by run control |
| cnt | output | CNT_W (16) | Current counter value |
| zero_evt | output | 1 | Counter-at-zero strobe |
| prd_evt | output | 1 | Counter-at-period strobe |
| dir_down | output | 1 | Current count direction, 1 = down |

## Verification
The bench builds the block with its default CNT_W of 16 and writes small periods (2 to 6) at run time. Every wrap, reversal, shadow hand-over and stop corner therefore shows up within a few ticks. The prescaler table covers both divider fields separately and together, up to the largest product of 1792. Because the cycle length is measured between zero strobes, the result does not depend on the prescaler phase.

// File: rtl/pwm_tbase_pkg.sv
// Package: shared field positions, encodings and the decoded control record
// for the PWM time-base counter. Assumes a 16-bit control word.
package pwm_tbase_pkg;

    localparam int REG_W    = 16;   // width of the write data port
    localparam int DIV_W    = 3;    // width of each prescaler field
    localparam int MODE_LSB = 0;    // count mode field, 2 bits
    localparam int LOAD_BIT = 3;    // 1 = period writes act at once
    localparam int PSL_LSB  = 7;    // linear divider field (x2 per step)
    localparam int PSP_LSB  = 10;   // power-of-two divider field
    localparam int RUN_LSB  = 14;   // run-control field, 2 bits

    typedef enum logic [1:0] {
        CM_UP   = 2'b00,
        CM_DOWN = 2'b01,
        CM_UPDN = 2'b10,
        CM_FRZ  = 2'b11
    } cmode_e;

    typedef enum logic [1:0] {
        RC_HALT_NOW = 2'b00,
        RC_HALT_CYC = 2'b01,
        RC_FREE_A   = 2'b10,
        RC_FREE_B   = 2'b11
    } runctl_e;

    typedef struct packed {
        runctl_e            run;
        logic [DIV_W-1:0]   ps_pow;
        logic [DIV_W-1:0]   ps_lin;
        logic               imm;
        cmode_e             mode;
    } tb_cfg_t;

    localparam tb_cfg_t CFG_RST = '{run: RC_HALT_NOW, ps_pow: '0, ps_lin: '0,
                                    imm: 1'b0, mode: CM_FRZ};

endpackage

// File: rtl/pwm_tb_prescale.sv
// Module: pwm_tb_prescale
// Generates a one-cycle tick enable every 2^ps_pow * (ps_lin ? 2*ps_lin : 1)
// system clocks. Assumes the divide fields may change at any time; a smaller
// divide takes effect by restarting on the next clock.
module pwm_tb_prescale
    import pwm_tbase_pkg::*;
#(
    parameter int PDIV_W = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PDIV_W-1:0] ps_pow,
    input  logic [PDIV_W-1:0] ps_lin,
    output logic              tick
);
    // Largest divide: 2^(2^PDIV_W-1) * 2*(2^PDIV_W-1)
    localparam int POW_MAX = (2 ** PDIV_W) - 1;
    localparam int LIN_MAX = 2 * ((2 ** PDIV_W) - 1);
    localparam int PRE_W   = POW_MAX + $clog2(LIN_MAX + 1);

    logic [PRE_W-1:0] lin_fac;
    logic [PRE_W-1:0] div_n;
    logic [PRE_W-1:0] div_m1;
    logic [PRE_W-1:0] pre_q;

    // Purpose: form the total divide from the two coded fields
    always_comb begin
        lin_fac = (ps_lin == '0) ? PRE_W'(1) : PRE_W'({ps_lin, 1'b0});
        div_n   = lin_fac << ps_pow;
        div_m1  = div_n - PRE_W'(1);
        tick    = (pre_q >= div_m1);
    end

    // Purpose: count system clocks between ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> (pre_q == $past(pre_q) + PRE_W'(1))) else $error("prescale step"); // R2

    AST_DIV1_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_pow == '0 && ps_lin == '0) |=>
        (tick || ps_pow != '0 || ps_lin != '0)) else $error("divide-by-1 gap"); // R2

endmodule

// File: rtl/pwm_tb_regs.sv
// Module: pwm_tb_regs
// Holds the decoded control word and the active/shadow period pair.
// Assumes CNT_W <= 16. An immediate-mode period write wins over a
// same-cycle shadow transfer; a shadow write in the cycle of a zero
// transfer reaches the active register at the following zero.
module pwm_tb_regs
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             zero_evt,
    output tb_cfg_t          cfg,
    output logic [CNT_W-1:0] prd_eff
);
    tb_cfg_t          cfg_q;
    logic [CNT_W-1:0] prd_act;
    logic [CNT_W-1:0] prd_shd;
    logic             xfer;
    logic             wr_ctl;
    logic             wr_prd;
    logic             unused_bits;

    assign unused_bits = ^{wr_data[13], wr_data[6:4], wr_data[2]};

    // Purpose: decode write targets and the shadow transfer condition
    always_comb begin
        wr_ctl  = wr_en && !wr_sel;
        wr_prd  = wr_en && wr_sel;
        xfer    = zero_evt && !cfg_q.imm;
        prd_eff = xfer ? prd_shd : prd_act;
        cfg     = cfg_q;
    end

    // Purpose: capture the control fields on a control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (wr_ctl) begin
            cfg_q.run    <= runctl_e'(wr_data[RUN_LSB +: 2]);
            cfg_q.ps_pow <= wr_data[PSP_LSB +: DIV_W];
            cfg_q.ps_lin <= wr_data[PSL_LSB +: DIV_W];
            cfg_q.imm    <= wr_data[LOAD_BIT];
            cfg_q.mode   <= cmode_e'(wr_data[MODE_LSB +: 2]);
        end
    end

    // Purpose: maintain shadow and active period registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_shd <= '0;
            prd_act <= '0;
        end else begin
            if (wr_prd) begin
                prd_shd <= wr_data[CNT_W-1:0];
            end
            if (wr_prd && cfg_q.imm) begin
                prd_act <= wr_data[CNT_W-1:0];
            end else if (xfer) begin
                prd_act <= prd_shd;
            end
        end
    end

    AST_IMM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prd && cfg_q.imm) |=> (prd_act == $past(wr_data[CNT_W-1:0]))) else $error("imm load"); // R8

    AST_SHD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.imm && !zero_evt) |=> $stable(prd_act)) else $error("shadow leak"); // R7

endmodule

// File: rtl/pwm_tb_counter.sv
// Module: pwm_tb_counter
// The time-base counter proper: applies count mode, run/stop qualification
// and produces the zero and period strobes. Assumes tick is a one-cycle
// enable and prd_eff already reflects a same-tick shadow transfer.
module pwm_tb_counter
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             halt,
    input  cmode_e           mode,
    input  runctl_e          run,
    input  logic [CNT_W-1:0] prd_eff,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             dir_down
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             dir_q;
    logic             dir_d;
    logic             hold;
    logic             adv;

    // Purpose: decide whether the halt request stops this tick
    always_comb begin
        unique case (run)
            RC_HALT_NOW: hold = halt;
            RC_HALT_CYC: hold = halt && (cnt_q == '0);
            default:     hold = 1'b0;
        endcase
        adv      = tick && (mode != CM_FRZ) && !hold;
        zero_evt = adv && (cnt_q == '0);
        prd_evt  = adv && (cnt_q == prd_eff);
        dir_down = (mode == CM_DOWN) || ((mode == CM_UPDN) && dir_q);
        cnt      = cnt_q;
    end

    // Purpose: next counter value and direction per count mode
    always_comb begin
        cnt_d = cnt_q;
        dir_d = (mode == CM_UPDN) ? dir_q : 1'b0;
        if (adv) begin
            unique case (mode)
                CM_UP: begin
                    cnt_d = (cnt_q >= prd_eff) ? '0 : cnt_q + CNT_W'(1);
                end
                CM_DOWN: begin
                    cnt_d = (cnt_q == '0) ? prd_eff : cnt_q - CNT_W'(1);
                end
                CM_UPDN: begin
                    if (!dir_q) begin
                        if (cnt_q >= prd_eff) begin
                            dir_d = 1'b1;
                            cnt_d = (cnt_q == '0) ? '0 : cnt_q - CNT_W'(1);
                        end else begin
                            cnt_d = cnt_q + CNT_W'(1);
                        end
                    end else if (cnt_q == '0) begin
                        dir_d = 1'b0;
                        cnt_d = (prd_eff == '0) ? '0 : CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    // Purpose: state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dir_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_evt && mode == CM_UP) |=> (cnt_q == '0)) else $error("up wrap"); // R3

    AST_UPDN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (prd_evt && mode == CM_UPDN && prd_eff != '0) |=> dir_q) else $error("updown turn"); // R5

    AST_FRZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_FRZ) |=> $stable(cnt_q)) else $error("freeze moved"); // R6

    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && run == RC_HALT_NOW) |=> $stable(cnt_q)) else $error("stop-now moved"); // R9

    AST_STOP_CYC: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && run == RC_HALT_CYC && cnt_q == '0) |=> (cnt_q == '0)) else $error("stop-cycle left zero"); // R10

    AST_ZERO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && prd_eff != '0) |=> !zero_evt) else $error("zero strobe wide"); // R12

endmodule

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase (top)
// PWM time-base: register port, two-stage prescaler and mode counter.
// Assumes a single clock domain and a write port driven synchronously.
module pwm_timebase
    import pwm_tbase_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [15:0]      wr_data,
    input  logic             dbg_halt,
    output logic [CNT_W-1:0] cnt,
    output logic             zero_evt,
    output logic             prd_evt,
    output logic             dir_down
);
    tb_cfg_t          cfg;
    logic [CNT_W-1:0] prd_eff;
    logic             tick;

    pwm_tb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .zero_evt (zero_evt),
        .cfg      (cfg),
        .prd_eff  (prd_eff)
    );

    pwm_tb_prescale #(.PDIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ps_pow (cfg.ps_pow),
        .ps_lin (cfg.ps_lin),
        .tick   (tick)
    );

    pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (dbg_halt),
        .mode     (cfg.mode),
        .run      (cfg.run),
        .prd_eff  (prd_eff),
        .cnt      (cnt),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .dir_down (dir_down)
    );

    AST_RST_QUIET: assert property (@(posedge clk)
        (!rst_n) |=> (cnt == '0 && !dir_down)) else $error("reset state"); // R1

endmodule

// File: tb/pwm_timebase_tb.sv
// Bench for pwm_timebase: a prescale table walked by one loop, then
// directed tests for reset, each count mode, period loading and stops.
module pwm_timebase_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        dbg_halt = 1'b0;
    logic [15:0] cnt;
    logic        zero_evt;
    logic        prd_evt;
    logic        dir_down;

    int nchk = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pwm_timebase u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .dbg_halt (dbg_halt),
        .cnt      (cnt),
        .zero_evt (zero_evt),
        .prd_evt  (prd_evt),
        .dir_down (dir_down)
    );

    // Prescale table: power field, linear field, expected divide (R2)
    localparam int NROW = 7;
    localparam int TAB_P [NROW] = '{0, 1, 0, 0, 2, 3, 7};
    localparam int TAB_L [NROW] = '{0, 0, 1, 2, 3, 1, 7};
    localparam int TAB_N [NROW] = '{1, 2, 2, 4, 24, 16, 1792};

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Freeze with immediate load, set period, then apply the final control word
    task automatic start(input logic [15:0] ctl, input logic [15:0] per);
        wr(1'b0, 16'h000B);
        wr(1'b1, per);
        wr(1'b0, ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        // ---- R2: prescale table, cycle length between zero strobes = 3*N
        for (int i = 0; i < NROW; i++) begin
            logic [15:0] c;
            int k;
            c = 16'h0008;
            c[12:10] = 3'(TAB_P[i]);
            c[9:7]   = 3'(TAB_L[i]);
            do_reset();
            start(c, 16'd2);
            k = 0;
            while (!zero_evt && k < 5000) begin @(negedge clk); k++; end
            k = 0;
            do begin @(negedge clk); k++; end while (!zero_evt && k < 10000);
            chk(k == 3 * TAB_N[i], "R2 cycle length", k, 3 * TAB_N[i]);
        end

        // ---- R1 reset state, R6 frozen after reset
        do_reset();
        chk(cnt == 0, "R1 cnt", cnt, 0);
        chk(!zero_evt && !prd_evt, "R1 strobes", {zero_evt, prd_evt}, 0);
        chk(!dir_down, "R1 dir", dir_down, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cnt == 0 && !zero_evt, "R6 frozen from reset", cnt, 0);
        end

        // ---- R3 up mode, P=3
        do_reset();
        start(16'h0008, 16'd3);
        for (int i = 0; i < 8; i++) begin
            chk(cnt == 16'(i % 4), "R3 up cnt", cnt, i % 4);
            chk(prd_evt == (i % 4 == 3), "R3 up prd_evt", prd_evt, i % 4 == 3);
            chk(zero_evt == (i % 4 == 0), "R3 up zero_evt", zero_evt, i % 4 == 0);
            chk(!dir_down, "R3 up dir", dir_down, 0);
            @(negedge clk);
        end

        // ---- R4 down mode, P=3
        do_reset();
        start(16'h0009, 16'd3);
        for (int i = 0; i < 8; i++) begin
            int e;
            e = (4 - (i % 4)) % 4;
            chk(cnt == 16'(e), "R4 down cnt", cnt, e);
            chk(prd_evt == (e == 3), "R4 down prd_evt", prd_evt, e == 3);
            chk(dir_down, "R4 down dir", dir_down, 1);
            @(negedge clk);
        end

        // ---- R5 up-down mode, P=3
        begin
            int ec [9] = '{0, 1, 2, 3, 2, 1, 0, 1, 2};
            int ed [9] = '{0, 0, 0, 0, 1, 1, 1, 0, 0};
            do_reset();
            start(16'h000A, 16'd3);
            for (int i = 0; i < 9; i++) begin
                chk(cnt == 16'(ec[i]), "R5 updown cnt", cnt, ec[i]);
                chk(dir_down == ed[i][0], "R5 updown dir", dir_down, ed[i]);
                @(negedge clk);
            end
        end

        // ---- R6 freeze mid-count, P=5
        do_reset();
        start(16'h0008, 16'd5);
        repeat (2) @(negedge clk);
        wr(1'b0, 16'h000B);
        for (int i = 0; i < 4; i++) begin
            chk(cnt == 4, "R6 freeze hold", cnt, 4);
            chk(!zero_evt && !prd_evt, "R6 freeze strobes", {zero_evt, prd_evt}, 0);
            @(negedge clk);
        end

        // ---- R7 shadow load: period 5 active, write 2 at count 3
        begin
            int ec [6] = '{4, 5, 0, 1, 2, 0};
            int ep [6] = '{0, 1, 0, 0, 1, 0};
            do_reset();
            start(16'h0000, 16'd5);
            repeat (2) @(negedge clk);
            wr(1'b1, 16'd2);
            for (int i = 0; i < 6; i++) begin
                chk(cnt == 16'(ec[i]), "R7 shadow cnt", cnt, ec[i]);
                chk(prd_evt == ep[i][0], "R7 shadow prd_evt", prd_evt, ep[i]);
                @(negedge clk);
            end
        end

        // ---- R8 immediate load: period 6, then 2 at once
        begin
            int ec [4] = '{2, 0, 1, 2};
            do_reset();
            start(16'h0008, 16'd6);
            wr(1'b1, 16'd2);
            for (int i = 0; i < 4; i++) begin
                chk(cnt == 16'(ec[i]), "R8 imm cnt", cnt, ec[i]);
                chk(prd_evt == (ec[i] == 2), "R8 imm prd_evt", prd_evt, ec[i] == 2);
                @(negedge clk);
            end
        end

        // ---- R9 stop on next tick, P=5
        do_reset();
        start(16'h0008, 16'd5);
        repeat (2) @(negedge clk);
        dbg_halt = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cnt == 2, "R9 stop-now hold", cnt, 2);
            chk(!zero_evt && !prd_evt, "R9 stop-now strobes", {zero_evt, prd_evt}, 0);
        end
        dbg_halt = 1'b0;
        @(negedge clk);
        chk(cnt == 3, "R9 resume", cnt, 3);

        // ---- R10 stop at cycle end, P=3
        do_reset();
        start(16'h4008, 16'd3);
        repeat (2) @(negedge clk);
        dbg_halt = 1'b1;
        @(negedge clk);
        chk(cnt == 3 && prd_evt, "R10 finishes cycle", cnt, 3);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(cnt == 0, "R10 hold at zero", cnt, 0);
            chk(!zero_evt, "R10 no strobe", zero_evt, 0);
        end
        dbg_halt = 1'b0;
        @(negedge clk);
        chk(cnt == 1, "R10 resume", cnt, 1);

        // ---- R11 free run ignores halt, P=3
        do_reset();
        dbg_halt = 1'b1;
        start(16'hC008, 16'd3);
        for (int i = 0; i < 6; i++) begin
            chk(cnt == 16'(i % 4), "R11 free run cnt", cnt, i % 4);
            @(negedge clk);
        end
        dbg_halt = 1'b0;

        // ---- R12 strobe width with divide 4, P=2
        begin
            int nz = 0;
            int np = 0;
            do_reset();
            start(16'h0808, 16'd2);
            for (int i = 0; i < 24; i++) begin
                if (zero_evt) begin
                    nz++;
                    chk(cnt == 0, "R12 zero strobe at zero", cnt, 0);
                end
                if (prd_evt) np++;
                @(negedge clk);
            end
            chk(nz == 2, "R12 zero strobe count", nz, 2);
            chk(np == 2, "R12 period strobe count", np, 2);
        end

        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule